// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block services an instruction cache miss. When the fetch side reports a miss, the controller issues one burst read of a whole four-word line. The returning words are collected in a line buffer. The bus returns the missed word first, then the rest of the line in rising word order, wrapping past the end of the line back to its first word. The missed word goes to the fetch unit in the cycle it arrives. Later fetches that fall inside the line being filled are served from the buffer, or bypassed straight from the bus in the beat that carries them. A fetch for a word that has not yet arrived is stalled.

A bus error on the first beat raises a machine-check output. A bus error on any later beat spoils the line. In both cases the line is neither used for hits nor written to the cache. A line that the bus marks non-cacheable on its first beat stays only in the buffer, and each of its words can be handed out once. A clean, cacheable line is written to the cache array in one write. That write happens in the first cycle after the fill in which the array is not busy serving a fetch. The buffer keeps the line for stream hits until the next miss is accepted.

Top module: `line_fill_ctrl`

## Requirements
- R1: A miss_valid seen while fill_busy is low starts a fill. In the next cycle bus_req is high for exactly one cycle, and bus_addr carries the missed address unchanged until the next miss. fill_busy stays high until the fill ends. A miss_valid seen while fill_busy is high is ignored.
- R2: Line words are numbered by fetch address bits [3:2]. The k-th data beat of a fill (k = 0..3) is stored as line word (c + k) mod 4, where c is bits [3:2] of the missed address. In the written line, word i sits at array_line bits [32*i+31:32*i].
- R3: On the first beat, if bus_err is low, fetch_valid is high in that same cycle and fetch_data equals bus_data, whether or not fetch_req is high.
- R4: A fetch_req whose address bits [ADDR_W-1:4] match the line being filled (or held) is a stream hit when its word is already stored, or is arriving without error in this beat. A stream hit drives fetch_valid high in the same cycle. The data comes from the buffer, or from bus_data in the arriving beat.
- R5: A fetch_req inside the line for a word whose beat has not yet come drives fetch_stall high and fetch_valid low. The exception is the first-beat forward of R3. fetch_stall is never high together with fetch_valid.
- R6: bus_err on the first beat drives machine_check high in that cycle, with fetch_valid low. The line then gives no hits and no stalls, and it is not written to the array.
- R7: bus_err on beat 1, 2 or 3 spoils the line. From the next cycle, fetches into it give neither fetch_valid nor fetch_stall, and no array write follows.
- R8: After four error-free beats of a cacheable line, array_we goes high for one cycle. This is the first cycle after the last beat in which array_busy is low. array_addr is the missed address with bits [3:0] cleared. array_we is never high while array_busy is high.
- R9: bus_nc is sampled only on the first beat. If it is high, the line is never written to the array, and each word is delivered at most once. The first-beat forward counts as a delivery. A later fetch of a delivered word gives neither fetch_valid nor fetch_stall.
- R10: A line stays in the buffer after the fill ends, and stream hits are served from it while the controller is idle, until the next miss is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| miss_valid | input | 1 | Miss request |
| miss_addr | input | ADDR_W | Byte address of the missed instruction |
| fill_busy | output | 1 | A fill or array write is in progress |
| bus_req | output | 1 | One-cycle burst read request |
| bus_addr | output | ADDR_W | Address of the burst (missed word) |
| bus_dvalid | input | 1 | Data beat present |
| bus_data | input | DATA_W | Beat data |
| bus_err | input | 1 | Beat carries a bus error |
| bus_nc | input | 1 | Non-cacheable flag, valid with the first beat |
| fetch_req | input | 1 | Fetch unit request |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_valid | output | 1 | fetch_data is valid this cycle |
| fetch_data | output | DATA_W | Instruction word to the fetch unit |
| fetch_stall | output | 1 | Requested word of the filling line not yet arrived |
| machine_check | output | 1 | Error on the missed word |
| array_busy | input | 1 | Cache array serving a fetch this cycle |
| array_we | output | 1 | Line write strobe to the array |
| array_addr | output | ADDR_W | Line-aligned write address |
| array_line | output | WORDS*DATA_W | Line data, word i in slice i |

## Verification
The bench builds the block with a 16-bit address, 32-bit words and a four-word line. The short address lets random fetch addresses reuse tags cheaply. Fetches are biased into the current line, so every word index can be hit, stalled on, bypassed or refused, against every critical-word position. Random gaps between beats and a mostly-busy array push the array write through long waits. Per-fill choices of error beat and non-cacheable flag cover every error position and single-use consumption.

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  output logic                    fill_busy,
  output logic                    bus_req,
  output logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_dvalid,
  input  logic [DATA_W-1:0]       bus_data,
  input  logic                    bus_err,
  input  logic                    bus_nc,
  input  logic                    fetch_req,
  input  logic [ADDR_W-1:0]       fetch_addr,
  output logic                    fetch_valid,
  output logic [DATA_W-1:0]       fetch_data,
  output logic                    fetch_stall,
  output logic                    machine_check,
  input  logic                    array_busy,
  output logic                    array_we,
  output logic [ADDR_W-1:0]       array_addr,
  output logic [WORDS*DATA_W-1:0] array_line
);
  localparam int OFF    = $clog2(DATA_W/8);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int TAG_LO = OFF + IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL, S_WR} st_t;

  st_t                          st;
  logic [ADDR_W-1:0]            addr_q;
  logic [IDX_W-1:0]             k;
  logic [WORDS-1:0]             arr, vld;
  logic [WORDS-1:0][DATA_W-1:0] mem;
  logic                         ok_q, nc_q, live_q;

  logic [IDX_W-1:0] crit, cur, widx;
  logic beat, first, last, nc_now, in_line, on_bus, fwd, buf_hit, take_bus;

  assign crit     = addr_q[OFF +: IDX_W];
  assign cur      = crit + k;
  assign widx     = fetch_addr[OFF +: IDX_W];
  assign beat     = (st == S_FILL) && bus_dvalid;
  assign first    = beat && (k == '0);
  assign last     = beat && (k == IDX_W'(WORDS-1));
  assign nc_now   = first ? bus_nc : nc_q;
  assign in_line  = live_q && ok_q && (fetch_addr[ADDR_W-1:TAG_LO] == addr_q[ADDR_W-1:TAG_LO]);
  assign on_bus   = beat && !bus_err && (cur == widx);
  assign fwd      = first && !bus_err;
  assign buf_hit  = fetch_req && in_line && (vld[widx] || on_bus);
  assign take_bus = fwd || (fetch_req && in_line && on_bus);

  assign fetch_valid   = fwd || buf_hit;
  assign fetch_data    = (fwd || on_bus) ? bus_data : mem[widx];
  assign fetch_stall   = fetch_req && in_line && !arr[widx] && !on_bus && !fwd;
  assign machine_check = first && bus_err;

  assign fill_busy  = (st != S_IDLE);
  assign bus_req    = (st == S_REQ);
  assign bus_addr   = addr_q;
  assign array_we   = (st == S_WR) && !array_busy;
  assign array_addr = {addr_q[ADDR_W-1:TAG_LO], {TAG_LO{1'b0}}};
  assign array_line = mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      k      <= '0;
      arr    <= '0;
      vld    <= '0;
      mem    <= '0;
      ok_q   <= 1'b0;
      nc_q   <= 1'b0;
      live_q <= 1'b0;
    end else begin
      if (nc_q && buf_hit && !on_bus) vld[widx] <= 1'b0;
      case (st)
        S_IDLE: if (miss_valid) begin
          st     <= S_REQ;
          addr_q <= miss_addr;
          k      <= '0;
          arr    <= '0;
          vld    <= '0;
          ok_q   <= 1'b1;
          nc_q   <= 1'b0;
          live_q <= 1'b1;
        end
        S_REQ: st <= S_FILL;
        S_FILL: if (beat) begin
          k        <= k + 1'b1;
          arr[cur] <= 1'b1;
          mem[cur] <= bus_data;
          if (first) nc_q <= bus_nc;
          if (bus_err) ok_q <= 1'b0;
          else vld[cur] <= !(nc_now && take_bus);
          if (last) st <= (ok_q && !bus_err && !nc_now) ? S_WR : S_IDLE;
        end
        S_WR: if (!array_busy) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_req_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_busy && miss_valid) |=> (bus_req && bus_addr == $past(miss_addr)));
  a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);
  a_r5_stall_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> !fetch_valid);
  a_r6_mchk_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    machine_check |-> (bus_dvalid && bus_err && !fetch_valid));
  a_r8_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    array_we |-> !array_busy);
  a_r8_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    array_we |=> !array_we);
  a_r9_nc_never_written: assert property (@(posedge clk) disable iff (!rst_n)
    array_we |-> !nc_q);
endmodule

// File: tb/line_fill_ctrl_test.sv
`timescale 1ns/1ps
module line_fill_ctrl_test;
  localparam int AW = 16, DW = 32, NW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, miss_valid, fill_busy, bus_req, bus_dvalid, bus_err, bus_nc;
  logic fetch_req, fetch_valid, fetch_stall, machine_check, array_busy, array_we;
  logic [AW-1:0] miss_addr, bus_addr, fetch_addr, array_addr;
  logic [DW-1:0] bus_data, fetch_data;
  logic [NW*DW-1:0] array_line;

  line_fill_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .fill_busy(fill_busy), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_dvalid(bus_dvalid), .bus_data(bus_data), .bus_err(bus_err), .bus_nc(bus_nc),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .fetch_stall(fetch_stall), .machine_check(machine_check),
    .array_busy(array_busy), .array_we(array_we), .array_addr(array_addr),
    .array_line(array_line));

  int n_chk = 0, n_fail = 0;

  // bench model of the requirements
  int m_phase, m_k;
  logic [AW-1:0] m_addr, m_miss;
  bit m_arr[NW], m_val[NW];
  logic [DW-1:0] m_dat[NW], sc_bd[NW];
  bit m_ok, m_nc, m_live;
  bit go;
  logic [AW-1:0] sc_addr;
  int sc_err, sc_dv, sc_busy;
  bit sc_nc;
  bit e_beat, e_inline, e_onbus, e_fwd, e_bufhit;
  int e_cur, e_widx;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic string lab_fetch();
    if (e_fwd) return "R3";
    if (m_live && !m_ok) return "R7";
    if (m_nc) return "R9";
    if (m_phase == 0) return "R10";
    return "R4";
  endfunction

  task automatic compare();
    bit exp_valid, exp_stall, exp_we;
    logic [DW-1:0] exp_data;
    string lf;
    e_cur    = (int'(m_addr[3:2]) + m_k) % NW;
    e_widx   = int'(fetch_addr[3:2]);
    e_beat   = (m_phase == 2) && bus_dvalid;
    e_fwd    = e_beat && (m_k == 0) && !bus_err;
    e_inline = m_live && m_ok && (fetch_addr[AW-1:4] == m_addr[AW-1:4]);
    e_onbus  = e_beat && !bus_err && (e_cur == e_widx);
    e_bufhit = fetch_req && e_inline && (m_val[e_widx] || e_onbus);
    exp_valid = e_fwd || e_bufhit;
    exp_data  = (e_fwd || e_onbus) ? bus_data : m_dat[e_widx];
    exp_stall = fetch_req && e_inline && !m_arr[e_widx] && !e_onbus && !e_fwd;
    exp_we    = (m_phase == 3) && !array_busy;
    lf = lab_fetch();
    chk({lf, " fetch_valid"}, 64'(fetch_valid), 64'(exp_valid));
    if (exp_valid) chk({lf, " fetch_data"}, 64'(fetch_data), 64'(exp_data));
    chk("R5 fetch_stall", 64'(fetch_stall), 64'(exp_stall));
    chk("R6 machine_check", 64'(machine_check), 64'(e_beat && m_k == 0 && bus_err));
    chk("R1 bus_req", 64'(bus_req), 64'(m_phase == 1));
    chk("R1 fill_busy", 64'(fill_busy), 64'(m_phase != 0));
    if (m_phase != 0) chk("R1 bus_addr", 64'(bus_addr), 64'(m_miss));
    chk(!m_ok ? "R7 array_we" : (m_nc ? "R9 array_we" : "R8 array_we"), 64'(array_we), 64'(exp_we));
    if (exp_we) begin
      chk("R8 array_addr", 64'(array_addr), 64'({m_addr[AW-1:4], 4'b0}));
      for (int j = 0; j < NW; j++)
        chk("R2 array word order", 64'(array_line[((int'(m_addr[3:2]) + j) % NW)*DW +: DW]), 64'(sc_bd[j]));
    end
  endtask

  task automatic update();
    bit ncn;
    if (m_nc && e_bufhit && !e_onbus) m_val[e_widx] = 0;
    case (m_phase)
      0: if (miss_valid) begin
        m_phase = 1; m_miss = miss_addr; m_addr = {miss_addr[AW-1:2], 2'b00}; m_k = 0;
        for (int j = 0; j < NW; j++) begin m_arr[j] = 0; m_val[j] = 0; end
        m_ok = 1; m_nc = 0; m_live = 1;
      end
      1: m_phase = 2;
      2: if (e_beat) begin
        ncn = (m_k == 0) ? bus_nc : m_nc;
        if (m_k == 0) m_nc = bus_nc;
        m_arr[e_cur] = 1;
        m_dat[e_cur] = bus_data;
        sc_bd[m_k] = bus_data;
        if (bus_err) m_ok = 0;
        else m_val[e_cur] = !(ncn && ((m_k == 0) || (fetch_req && e_inline && e_widx == e_cur)));
        if (m_k == NW-1) m_phase = (m_ok && !ncn) ? 3 : 0;
        m_k++;
      end
      3: if (!array_busy) m_phase = 0;
      default: m_phase = 0;
    endcase
  endtask

  task automatic cycle();
    @(negedge clk);
    if (m_phase == 0) begin
      miss_valid = go; miss_addr = sc_addr;
    end else begin
      miss_valid = ($urandom % 6 == 0); miss_addr = AW'($urandom);
    end
    bus_dvalid = ($urandom % 100) < sc_dv;
    bus_data   = $urandom;
    bus_nc     = (m_k == 0) ? sc_nc : 1'($urandom);
    bus_err    = (m_phase == 2) ? (bus_dvalid && m_k == sc_err) : 1'($urandom);
    fetch_req  = ($urandom % 10) < 7;
    fetch_addr = ($urandom % 5 != 0) ? {m_addr[AW-1:4], 2'($urandom), 2'b00} : AW'($urandom);
    array_busy = ($urandom % 100) < sc_busy;
    #1 compare();
    @(posedge clk);
    update();
  endtask

  initial begin
    #(4ns * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; miss_valid = 0; miss_addr = '0; bus_dvalid = 0; bus_data = '0;
    bus_err = 0; bus_nc = 0; fetch_req = 0; fetch_addr = '0; array_busy = 0;
    m_phase = 0; m_k = 0; m_addr = '0; m_miss = '0; m_ok = 0; m_nc = 0; m_live = 0; go = 0;
    for (int j = 0; j < NW; j++) begin m_arr[j] = 0; m_val[j] = 0; m_dat[j] = '0; sc_bd[j] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset bus_req", 64'(bus_req), 64'(0));
    chk("R1 reset fill_busy", 64'(fill_busy), 64'(0));
    chk("R10 reset fetch_valid", 64'(fetch_valid), 64'(0));
    chk("R8 reset array_we", 64'(array_we), 64'(0));
    @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < 120; s++) begin
      int guard;
      sc_addr = AW'($urandom); sc_err = -1; sc_nc = 0; sc_dv = 40 + $urandom % 61;
      sc_busy = $urandom % 80;
      case (s)
        0: begin sc_addr = 16'h0ABC; sc_dv = 100; sc_busy = 0; end   // R2 crit word 3
        1: sc_err = 0;                                                // R6
        2: sc_err = 2;                                                // R7
        3: begin sc_nc = 1; sc_dv = 30; end                           // R9
        4: sc_busy = 95;                                              // R8 long wait
        5: sc_err = 3;                                                // R7 last beat
        default: begin
          if ($urandom % 5 == 0) sc_err = $urandom % NW;
          sc_nc = ($urandom % 4 == 0);
        end
      endcase
      go = 1; guard = 0;
      while (m_phase == 0 && guard < 400) begin cycle(); guard++; end
      go = 0;
      while (m_phase != 0 && guard < 400) begin cycle(); guard++; end
      if (guard >= 400) begin
        n_chk++; n_fail++;
        $display("FAIL R1 fill never completed actual=%0d expected<400", guard);
      end
      repeat (1 + $urandom % 5) cycle();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule